// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM with Byte Lanes

This block is a cycle-accurate, synthesizable model of a synchronous pipelined burst SRAM organised as words of four 8-bit lanes. Every control except the output enable, the sleep input and the burst-order select is sampled on the rising clock edge. An access begins when either of two active-low address strobes is taken: the address is latched as the base of a new burst and a 2-bit counter is cleared. Later cycles without a strobe continue the burst. The advance input steps the counter, and the counter sets the two low address bits in either linear or interleaved order. The two strobes follow different rules when the first chip select is inactive.

Reads are pipelined. The data for an access registered on one edge is driven from the next edge onward. The data bus is split into a write-data input and a read-data output with a drive flag, so pad drivers stay outside the block. Writes are byte-masked, and a global write stores every lane. A sleep input stops all accesses. After sleep is released, the burst is not resumed; only a new strobe starts a new access.

`ADDR_W` defaults to 10 (1K words) so that the model stays small. Setting it to 17 gives the full 128K-word array.

Top module: `burst_sram`

## Requirements
- R1: A taken strobe starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise the strobe deselects the chip: that cycle and the following continuation cycles neither write nor drive `dq_drive`, until the next taken strobe.
- R2: When `cpu_strb_n`=0 while `sel_a_n`=1, the CPU strobe is ignored. If `ctl_strb_n`=1 in that cycle, the cycle acts as a normal continuation of the current burst, and the base address and active state are kept.
- R3: When `ctl_strb_n`=0 and `sel_a_n`=1 (and the CPU strobe is not taken), the chip deselects. Continuation cycles after that make no access.
- R4: A taken strobe aborts any burst, latches `addr` as the base and clears the counter. The CPU strobe has priority when both strobes are taken. A CPU-strobe cycle is always a read, whatever the write inputs are. A controller-strobe cycle honours the write inputs.
- R5: In a continuation cycle with `step_n`=0, the counter advances by one before the access, and the counter wraps modulo 4. With `step_n`=1, the same address is accessed again. Address bits above bit 1 stay equal to those of the base.
- R6: Address bits [1:0] are (base[1:0] + count) mod 4 when `ilv_order`=0, and base[1:0] XOR count when `ilv_order`=1.
- R7: When `wr_all_n`=0, the access is a write of all four lanes, whatever `wr_n` and `lane_wr_n` are.
- R8: When `wr_all_n`=1 and `wr_n`=0, the access is a write of only the lanes whose `lane_wr_n[i]`=0. Lane i is `din[8i+7:8i]`. With no lane selected, nothing is stored and no read occurs.
- R9: A read access registered on edge E drives `dq_drive`=1 with the stored word on `dout` from edge E+1 until edge E+2. Write, deselect and idle accesses give `dq_drive`=0 and `dout`=0 in that window.
- R10: `rd_oe_n`=1 forces `dq_drive`=0 and `dout`=0 at once, without clocking, and leaves the pipeline unchanged.
- R11: While `nap`=1, clock edges make no access and end any burst, and the output is forced off at once. After `nap` falls, continuation cycles do nothing until a new strobe. Stored data is kept.
- R12: After synchronous reset, no burst is active and `dq_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, sampled when a strobe is taken |
| cpu_strb_n | input | 1 | CPU address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Depth-expansion select, active high |
| sel_c_n | input | 1 | Depth-expansion select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_n | input | 1 | Lane-masked write, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved (tie high by default) |
| nap | input | 1 | Sleep request, active high |
| rd_oe_n | input | 1 | Read output enable, active low, asynchronous |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, zero when not driven |
| dq_drive | output | 1 | High while dout carries valid read data |

## Verification
The bench goes after the points where the two strobes differ. A CPU strobe blocked by the primary select must let the burst run on, and a model that deselects on it would drop the next read. A CPU-strobe cycle carrying write controls must still read, so a model that wrote there would corrupt the word read back later. Start addresses with low bits 01 separate the two burst orders: a model with the orders swapped, or with no counter wrap, reads the wrong words. All sixteen lane masks are applied to one word whose value builds up from write to write, and global write is applied with conflicting lane selects, so any lane leak shows up. The sleep sequence issues advance and write continuations after wake: a model that resumes the old burst would drive data, or overwrite words that are read back afterwards.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic take_cpu;
        logic take_ctl;
        logic chip_on;
    } strobe_t;

    // Low address bits of a burst beat from start bits and beat count.
    function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        logic [1:0] r;
        if (ilv) r = start ^ cnt;
        else     r = start + cnt;
        return r;
    endfunction

endpackage

// File: rtl/bsram_lane_dec.sv
module bsram_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             wcmd,
    output logic [LANES-1:0] lane_mask
);
    always_comb begin
        wcmd = ~wr_all_n | ~wr_n;
        if (!wr_all_n)  lane_mask = '1;
        else if (!wr_n) lane_mask = ~lane_wr_n;
        else            lane_mask = '0;
    end
endmodule

// File: rtl/bsram_addr_ctrl.sv
module bsram_addr_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nap,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              step_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wcmd,
    input  logic              ilv_order,
    output acc_kind_e         acc_kind,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              active_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [1:0]        cnt_q
);
    strobe_t    dec;
    logic       taken;
    logic [1:0] cnt_nx;

    always_comb begin
        dec.take_cpu = ~cpu_strb_n & ~sel_a_n;
        dec.take_ctl = ~dec.take_cpu & ~ctl_strb_n;
        dec.chip_on  = ~sel_a_n & sel_b & ~sel_c_n;
        taken        = dec.take_cpu | dec.take_ctl;
        cnt_nx       = cnt_q + {1'b0, ~step_n};
    end

    always_comb begin
        acc_kind = ACC_NONE;
        acc_addr = {base_q[ADDR_W-1:2], burst_lsb(base_q[1:0], cnt_nx, ilv_order)};
        if (nap) begin
            acc_kind = ACC_NONE;
        end else if (taken) begin
            acc_addr = addr;
            if (dec.chip_on)
                acc_kind = (dec.take_ctl && wcmd) ? ACC_WRITE : ACC_READ;
        end else if (active_q) begin
            acc_kind = wcmd ? ACC_WRITE : ACC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else if (nap) begin
            active_q <= 1'b0;
        end else if (taken) begin
            base_q   <= addr;
            cnt_q    <= '0;
            active_q <= dec.chip_on;
        end else if (active_q) begin
            cnt_q    <= cnt_nx;
        end
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l])
                lane_mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            lane_q <= lane_mem[rd_addr];
        end

        assign rd_data[l*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/bsram_read_pipe.sv
module bsram_read_pipe
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_vld
);
    logic stage_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_rd <= 1'b0;
            out_vld  <= 1'b0;
            rd_addr  <= '0;
        end else begin
            stage_rd <= (acc_kind == ACC_READ);
            rd_addr  <= acc_addr;
            out_vld  <= stage_rd;
        end
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              step_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_all_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              ilv_order,
    input  logic              nap,
    input  logic              rd_oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dq_drive
);
    logic              wcmd;
    logic [LANES-1:0]  lane_mask;
    acc_kind_e         acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    logic              active_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [ADDR_W-1:0] rd_addr;
    logic              out_vld;
    logic [DATA_W-1:0] rd_data;
    logic              acc_vld;
    logic              acc_wr;

    bsram_lane_dec #(.LANES(LANES)) u_dec (
        .wr_all_n (wr_all_n),
        .wr_n     (wr_n),
        .lane_wr_n(lane_wr_n),
        .wcmd     (wcmd),
        .lane_mask(lane_mask)
    );

    bsram_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .nap       (nap),
        .addr      (addr),
        .cpu_strb_n(cpu_strb_n),
        .ctl_strb_n(ctl_strb_n),
        .step_n    (step_n),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .wcmd      (wcmd),
        .ilv_order (ilv_order),
        .acc_kind  (acc_kind),
        .acc_addr  (acc_addr),
        .active_q  (active_q),
        .base_q    (base_q),
        .cnt_q     (cnt_q)
    );

    assign acc_vld = (acc_kind != ACC_NONE);
    assign acc_wr  = (acc_kind == ACC_WRITE);

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk    (clk),
        .wr_en  (acc_wr),
        .wr_addr(acc_addr),
        .wr_mask(lane_mask),
        .wr_data(din),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    bsram_read_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .acc_kind(acc_kind),
        .acc_addr(acc_addr),
        .rd_addr (rd_addr),
        .out_vld (out_vld)
    );

    always_comb begin
        dq_drive = out_vld & ~rd_oe_n & ~nap;
        dout     = dq_drive ? rd_data : '0;
    end
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              nap,
    input logic              cpu_strb_n,
    input logic              ctl_strb_n,
    input logic              step_n,
    input logic              sel_a_n,
    input logic              wr_all_n,
    input logic              dq_drive,
    input logic              active_q,
    input logic [ADDR_W-1:0] base_q,
    input logic [1:0]        cnt_q,
    input logic              acc_vld,
    input logic              acc_wr,
    input logic [LANES-1:0]  lane_mask
);
    logic cpu_taken;
    logic no_strobe;
    assign cpu_taken = !cpu_strb_n && !sel_a_n;
    assign no_strobe = !cpu_taken && ctl_strb_n;

    // R3: controller strobe with primary select inactive leaves no read data
    assert_desel_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl_strb_n && sel_a_n && !nap) |=> ##1 !dq_drive);

    // R2: a blocked CPU strobe keeps the burst
    assert_cpu_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (active_q && !nap && !cpu_strb_n && sel_a_n && ctl_strb_n)
        |=> ($stable(base_q) && active_q));

    // R5: advancing steps the count by one
    assert_step_count_R5: assert property (@(posedge clk) disable iff (rst)
        (active_q && !nap && no_strobe && !step_n)
        |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R9: a write never produces read data
    assert_write_silent_R9: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> ##1 !dq_drive);

    // R11: sleep ends the burst
    assert_nap_ends_R11: assert property (@(posedge clk) disable iff (rst)
        nap |=> !active_q);

    // R11: with no burst and no strobe there is no access
    assert_idle_no_access_R11: assert property (@(posedge clk) disable iff (rst)
        (!active_q && cpu_strb_n && ctl_strb_n) |-> !acc_vld);

    // R7: global write selects every lane
    assert_global_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !wr_all_n) |-> (&lane_mask));
endmodule

bind burst_sram bsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .nap       (nap),
    .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n),
    .step_n    (step_n),
    .sel_a_n   (sel_a_n),
    .wr_all_n  (wr_all_n),
    .dq_drive  (dq_drive),
    .active_q  (active_q),
    .base_q    (base_q),
    .cnt_q     (cnt_q),
    .acc_vld   (acc_vld),
    .acc_wr    (acc_wr),
    .lane_mask (lane_mask)
);

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, step_n = 1'b1;
    logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          wr_all_n = 1'b1, wr_n = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          ilv_order = 1'b0, nap = 1'b0, rd_oe_n = 1'b0;
    logic [31:0]   din = '0;
    logic [31:0]   dout;
    logic          dq_drive;

    burst_sram u_burst_sram (
        .clk(clk), .rst(rst), .addr(addr),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_all_n(wr_all_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .ilv_order(ilv_order), .nap(nap), .rd_oe_n(rd_oe_n),
        .din(din), .dout(dout), .dq_drive(dq_drive)
    );

    always #5 clk = ~clk;

    typedef struct {
        int        due;
        bit        drv;
        bit [31:0] val;
        string     req;
    } exp_t;

    exp_t      sb_q[$];
    bit [31:0] ref_mem [1 << AW];
    int        ecount = 0;
    int        n_vec = 0;
    int        n_bad = 0;
    bit        done = 0;
    bit        m_act = 0;
    bit [AW-1:0] m_base = '0;
    bit [1:0]  m_cnt = '0;

    always @(posedge clk) ecount <= ecount + 1;

    function automatic bit [1:0] order_bits(bit [1:0] s, bit [1:0] c, bit ilv);
        return ilv ? (s ^ c) : 2'(s + c);
    endfunction

    // Reference model of one clock edge, built from the requirements
    function automatic void model(string req);
        bit tp, tc, ce, wc, rd, wr;
        bit [AW-1:0] acc;
        exp_t e;
        tp = !cpu_strb_n && !sel_a_n;
        tc = !tp && !ctl_strb_n;
        ce = !sel_a_n && sel_b && !sel_c_n;
        wc = !wr_all_n || !wr_n;
        rd = 0; wr = 0; acc = '0;
        if (nap) begin
            m_act = 0;
        end else if (tp || tc) begin
            m_base = addr; m_cnt = 0; m_act = ce;
            if (ce) begin acc = addr; wr = tc && wc; rd = !wr; end
        end else if (m_act) begin
            if (!step_n) m_cnt = m_cnt + 2'd1;
            acc = {m_base[AW-1:2], order_bits(m_base[1:0], m_cnt, ilv_order)};
            wr = wc; rd = !wr;
        end
        if (wr) begin
            for (int i = 0; i < 4; i++)
                if (!wr_all_n || !lane_wr_n[i]) ref_mem[acc][8*i +: 8] = din[8*i +: 8];
        end
        e.due = ecount + 2;
        e.drv = rd;
        e.val = rd ? ref_mem[acc] : 32'h0;
        e.req = req;
        sb_q.push_back(e);
    endfunction

    // Monitor: compares the design output with the scoreboard
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0 && sb_q[0].due == ecount) begin
            exp_t e;
            bit          drv_x;
            bit [31:0]   val_x;
            e = sb_q.pop_front();
            drv_x = e.drv && !rd_oe_n && !nap;
            val_x = drv_x ? e.val : 32'h0;
            n_vec++;
            if (dq_drive !== drv_x || dout !== val_x) begin
                n_bad++;
                $display("FAIL %s: drive=%0b dout=%h expected drive=%0b dout=%h",
                         e.req, dq_drive, dout, drv_x, val_x);
            end
        end
    end

    task automatic set_idle();
        cpu_strb_n = 1; ctl_strb_n = 1; step_n = 1;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        wr_all_n = 1; wr_n = 1; lane_wr_n = 4'hF;
    endtask

    task automatic tick(input string req);
        model(req);
        @(posedge clk);
        #1;
        set_idle();
    endtask

    task automatic ctl_read(input bit [AW-1:0] a, input string req);
        ctl_strb_n = 0; addr = a; tick(req);
    endtask

    task automatic ctl_write(input bit [AW-1:0] a, input bit g_n, input bit w_n,
                             input bit [3:0] b_n, input bit [31:0] d, input string req);
        ctl_strb_n = 0; addr = a; wr_all_n = g_n; wr_n = w_n; lane_wr_n = b_n; din = d;
        tick(req);
    endtask

    task automatic cpu_start(input bit [AW-1:0] a, input string req);
        cpu_strb_n = 0; addr = a; tick(req);
    endtask

    task automatic advance(input string req);
        step_n = 0; tick(req);
    endtask

    task automatic deselect(input string req);
        ctl_strb_n = 0; sel_a_n = 1; tick(req);
    endtask

    initial begin
        set_idle();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R12: reset state
        n_vec++;
        if (dq_drive !== 1'b0 || dout !== 32'h0) begin
            n_bad++;
            $display("FAIL R12: drive=%0b dout=%h expected drive=0 dout=0", dq_drive, dout);
        end
        deselect("R12");

        // R7: fill words 0..63 by global write
        for (int a = 0; a < 64; a++)
            ctl_write(AW'(a), 1'b0, 1'b1, 4'hF, 32'h5A00C300 ^ (a * 32'h01010101), "R7 fill");
        for (int a = 0; a < 4; a++) ctl_read(AW'(a * 7), "R9 single read");

        // R6 linear burst from low bits 01, then wrap and suspend (R5)
        ilv_order = 0;
        cpu_start(10'h011, "R4 cpu start");
        repeat (4) advance("R6 linear");
        step_n = 1; tick("R5 suspend");
        advance("R5 wrap");

        // R6 interleaved burst
        ilv_order = 1;
        cpu_start(10'h025, "R4 cpu start");
        repeat (3) advance("R6 interleaved");

        // R4: abort burst with controller strobe
        cpu_start(10'h029, "R4 cpu start");
        advance("R6 interleaved");
        ctl_read(10'h030, "R4 abort");
        advance("R4 new burst");

        // R2: CPU strobe blocked by primary select
        cpu_strb_n = 0; sel_a_n = 1; step_n = 0; addr = 10'h03F; tick("R2 blocked");
        advance("R2 continue");

        // R3: controller strobe with primary select high deselects
        deselect("R3 desel");
        advance("R3 quiet");
        advance("R3 quiet");

        // R1: depth-expansion selects
        cpu_strb_n = 0; sel_b = 0; addr = 10'h008; tick("R1 sel_b low");
        advance("R1 quiet");
        ctl_strb_n = 0; sel_c_n = 1; addr = 10'h009; tick("R1 sel_c high");
        advance("R1 quiet");
        cpu_strb_n = 0; ctl_strb_n = 0; sel_a_n = 1; addr = 10'h00A; tick("R1 both strobes desel");
        advance("R1 quiet");

        // R4: CPU-strobe cycle ignores write controls
        cpu_strb_n = 0; addr = 10'h005; wr_all_n = 0; din = 32'hDEADBEEF; tick("R4 cpu no write");
        ctl_read(10'h005, "R4 unchanged");

        // R8: every lane mask on one word
        for (int m = 0; m < 16; m++) begin
            ctl_write(10'h03A, 1'b1, 1'b0, 4'(m), {4{8'(m * 17 + 3)}}, "R8 lane write");
            ctl_read(10'h03A, "R8 lane readback");
        end

        // R7: global write overrides lane selects
        ctl_write(10'h03B, 1'b0, 1'b0, 4'b1011, 32'hA1B2C3D4, "R7 override");
        ctl_read(10'h03B, "R7 readback");
        ctl_write(10'h03C, 1'b0, 1'b1, 4'hF, 32'h0F1E2D3C, "R7 no lane sel");
        ctl_read(10'h03C, "R7 readback");

        // R5: burst write then burst read, linear order
        ilv_order = 0;
        ctl_write(10'h016, 1'b0, 1'b1, 4'hF, 32'h11111111, "R5 burst write");
        for (int k = 0; k < 3; k++) begin
            step_n = 0; wr_all_n = 0; din = 32'h22220000 + k; tick("R5 burst write");
        end
        cpu_start(10'h016, "R5 burst read");
        repeat (3) advance("R5 burst read");

        // R10: output enable gating
        ctl_read(10'h014, "R10 read");
        rd_oe_n = 1; deselect("R10 gated");
        rd_oe_n = 0;
        rd_oe_n = 1; ctl_read(10'h015, "R10 pipeline kept");
        rd_oe_n = 0; deselect("R10 pipeline kept");

        // R11: sleep and wake
        ilv_order = 1;
        ctl_read(10'h020, "R11 before nap");
        advance("R11 before nap");
        nap = 1; step_n = 0; tick("R11 nap");
        nap = 1; step_n = 0; tick("R11 nap");
        nap = 0;
        advance("R11 wake quiet");
        step_n = 0; wr_all_n = 0; din = 32'hBADBAD00; tick("R11 wake no write");
        for (int a = 32; a < 36; a++) ctl_read(AW'(a), "R11 contents kept");

        repeat (3) deselect("R9 drain");
        repeat (2) @(posedge clk);
        #1;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9: %0d results missing expected 0", sb_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule